// File: doc/BRIEF.md
# Internal RAM Chip-Select Decoder

This block produces the select for an on-chip RAM in a controller with a 20-bit address space. One 16-bit control register, written and read over a simple peripheral register port, holds a five-bit window base, a RAM enable and a show-read control. On every memory cycle the top five address bits are compared with the base. A hit asserts the RAM select and a ready output in the same cycle, so the access needs no wait states. The window can sit on any 32-Kbyte boundary.

Writing the register does not open the window by itself. The enable bit must also be 1. Show-read is a debug aid: internal RAM read data is copied, all 16 bits, onto the external multiplexed address/data bus. It is turned on either by the register's show bit or by an input pin sampled while reset is held. When the sampled pin value is 1, the show bit is ignored.

Top module: `iram_csel`

## Requirements
- R1: While `rst` is high on a clock edge, the enable bit and the show bit are cleared to 0. After reset, `reg_rdata[10:0]` reads 11'h1FF. The base field `reg_rdata[15:11]` has no defined reset value.
- R2: `reg_rdata` returns the stored base in bits 15:11, the show bit in bit 10 and the enable bit in bit 9. Bits 8:0 always read 1, whatever value was written to them.
- R3: A write with `reg_we` high loads `reg_wdata[15:9]` on that clock edge. The new value is visible on `reg_rdata` in the next cycle.
- R4: `ram_sel` is high in the same cycle as `cyc_valid` exactly when the enable bit is 1 and `cyc_addr[19:15]` equals the base field.
- R5: While the enable bit is 0, `ram_sel` stays low even if the base field matches the address. Writing the base alone does not open the window.
- R6: `ram_ready` equals `ram_sel` in every cycle, with no wait states.
- R7: `ext_oe` is high when a read cycle (`cyc_read`=1) hits the window and show-read is in force.
- R8: The value of `sr_pin` on the last clock edge with `rst` high is held until the next reset. If that value is 1, show-read is in force whatever the show bit is. Changes on `sr_pin` outside reset have no effect.
- R9: While `ext_oe` is high, `ext_data` carries all 16 bits of `ram_rdata`, including the lane a byte read would not use. Otherwise `ext_data` is 0.
- R10: Write cycles and cycles that miss the window never raise `ext_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_pin | input | 1 | Show-read force pin, sampled during reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 16 | Control register write data |
| reg_rdata | output | 16 | Control register read value |
| cyc_valid | input | 1 | Memory cycle present |
| cyc_addr | input | 20 | Memory cycle address |
| cyc_read | input | 1 | 1 for a read cycle, 0 for a write cycle |
| ram_rdata | input | 16 | Read data from the internal RAM |
| ram_sel | output | 1 | Internal RAM select |
| ram_ready | output | 1 | Zero-wait ready for the internal RAM |
| ext_oe | output | 1 | Drive enable for the external address/data bus |
| ext_data | output | 16 | Data driven onto the external bus |

## Verification
The select, ready, drive enable and external data depend only on logic. They are due in the same cycle as the address and read data, so the bench sets its inputs just after a rising edge and compares them at the following falling edge. A register write or a reset-time pin sample takes effect one edge later. The reference model updates its own state on the rising edge, so the first falling edge after a write already expects the new value. Each explicit check waits for that same falling edge.

// File: rtl/iram_csel_pkg.sv
package iram_csel_pkg;
  localparam int REG_W    = 16;
  localparam int BASE_W   = 5;
  localparam int BASE_LSB = 11;
  localparam int SHOW_BIT = 10;
  localparam int EN_BIT   = 9;
  localparam int RSV_W    = 9;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic              show;
    logic              en;
  } ctrl_t;
endpackage

// File: rtl/iram_csel_ctrl.sv
module iram_csel_ctrl
  import iram_csel_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  ctrl_t            wr_val,
  output ctrl_t            cur,
  output logic [REG_W-1:0] rd_val
);
  logic [BASE_W-1:0] base_q;
  logic              show_q;
  logic              en_q;

  // show and enable have a defined reset value
  always_ff @(posedge clk) begin
    if (rst) begin
      show_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (wr_en) begin
      show_q <= wr_val.show;
      en_q   <= wr_val.en;
    end
  end

  // the base field is left unreset on purpose
  always_ff @(posedge clk) begin
    if (!rst && wr_en) begin
      base_q <= wr_val.base;
    end
  end

  assign cur    = '{base: base_q, show: show_q, en: en_q};
  assign rd_val = {base_q, show_q, en_q, {RSV_W{1'b1}}};
endmodule

// File: rtl/iram_csel_pinlatch.sv
module iram_csel_pinlatch (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic pin_q
);
  // tracks the pin while reset is held; the last reset edge wins
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= pin;
    end
  end
endmodule

// File: rtl/iram_csel_match.sv
module iram_csel_match #(
  parameter int W = 5
) (
  input  logic [W-1:0] addr_hi,
  input  logic [W-1:0] base,
  output logic         hit
);
  logic [W-1:0] bit_eq;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_eq[i] = ~(addr_hi[i] ^ base[i]);
  end

  assign hit = &bit_eq;
endmodule

// File: rtl/iram_csel_drive.sv
module iram_csel_drive #(
  parameter int DATA_W = 16
) (
  input  logic              oe,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int LANES = DATA_W / 8;

  // every byte lane is driven, whichever lanes the access uses
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign dout[l*8 +: 8] = oe ? din[l*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/iram_csel.sv
module iram_csel
  import iram_csel_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sr_pin,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              cyc_valid,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic              cyc_read,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              ram_sel,
  output logic              ram_ready,
  output logic              ext_oe,
  output logic [DATA_W-1:0] ext_data
);
  localparam int WIN_LSB = ADDR_W - BASE_W;

  ctrl_t wr_val;
  ctrl_t cur;
  logic  pin_q;
  logic  win_hit;
  logic  show_act;
  logic  unused_bits;

  assign wr_val = '{base: reg_wdata[REG_W-1:BASE_LSB],
                    show: reg_wdata[SHOW_BIT],
                    en:   reg_wdata[EN_BIT]};
  assign unused_bits = ^{reg_wdata[RSV_W-1:0], cyc_addr[WIN_LSB-1:0]};

  iram_csel_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_we),
    .wr_val (wr_val),
    .cur    (cur),
    .rd_val (reg_rdata)
  );

  iram_csel_pinlatch u_pin (
    .clk   (clk),
    .rst   (rst),
    .pin   (sr_pin),
    .pin_q (pin_q)
  );

  iram_csel_match #(.W(BASE_W)) u_match (
    .addr_hi (cyc_addr[ADDR_W-1:WIN_LSB]),
    .base    (cur.base),
    .hit     (win_hit)
  );

  assign show_act  = pin_q | cur.show;
  assign ram_sel   = cyc_valid & cur.en & win_hit;
  assign ram_ready = ram_sel;
  assign ext_oe    = ram_sel & cyc_read & show_act;

  iram_csel_drive #(.DATA_W(DATA_W)) u_drive (
    .oe   (ext_oe),
    .din  (ram_rdata),
    .dout (ext_data)
  );
endmodule

// File: rtl/iram_csel_chk.sv
module iram_csel_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_we,
  input logic [15:0] reg_wdata,
  input logic [15:0] reg_rdata,
  input logic        cyc_valid,
  input logic [19:0] cyc_addr,
  input logic        cyc_read,
  input logic        ram_sel,
  input logic        ram_ready,
  input logic        ext_oe,
  input logic [15:0] ext_data,
  input logic        pin_q
);
  // R2
  rsv_ones_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[8:0] == 9'h1FF);

  // R3
  wr_load_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> reg_rdata[15:9] == $past(reg_wdata[15:9]));

  // R4
  sel_window_chk: assert property (@(posedge clk) disable iff (rst)
    ram_sel |-> (cyc_valid && reg_rdata[9] && cyc_addr[19:15] == reg_rdata[15:11]));

  // R5
  sel_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rdata[9] |-> !ram_sel);

  // R6
  zero_wait_chk: assert property (@(posedge clk) disable iff (rst)
    ram_ready == ram_sel);

  // R8
  pin_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(pin_q));

  // R9
  quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !ext_oe |-> ext_data == 16'h0000);

  // R10
  no_write_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (!cyc_read || !ram_sel) |-> !ext_oe);
endmodule

bind iram_csel iram_csel_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .cyc_valid (cyc_valid),
  .cyc_addr  (cyc_addr),
  .cyc_read  (cyc_read),
  .ram_sel   (ram_sel),
  .ram_ready (ram_ready),
  .ext_oe    (ext_oe),
  .ext_data  (ext_data),
  .pin_q     (pin_q)
);

// File: tb/sim_iram_csel.sv
module sim_iram_csel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sr_pin = 1'b0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        cyc_valid = 1'b0;
  logic [19:0] cyc_addr = '0;
  logic        cyc_read = 1'b0;
  logic [15:0] ram_rdata = '0;
  logic        ram_sel, ram_ready, ext_oe;
  logic [15:0] ext_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_base = 0, m_sr = 0, m_re = 0, m_pin = 0;
  bit base_known = 0;

  always #10 clk = ~clk;

  iram_csel u0 (
    .clk(clk), .rst(rst), .sr_pin(sr_pin), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_valid(cyc_valid),
    .cyc_addr(cyc_addr), .cyc_read(cyc_read), .ram_rdata(ram_rdata),
    .ram_sel(ram_sel), .ram_ready(ram_ready), .ext_oe(ext_oe),
    .ext_data(ext_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_sr  = 0;
      m_re  = 0;
      m_pin = int'(sr_pin);
    end else if (reg_we) begin
      m_base = int'(reg_wdata[15:11]);
      m_sr   = int'(reg_wdata[10]);
      m_re   = int'(reg_wdata[9]);
      base_known = 1;
    end
  end

  function automatic bit exp_sel();
    return cyc_valid && m_re == 1 && base_known && int'(cyc_addr[19:15]) == m_base;
  endfunction

  function automatic bit exp_oe();
    return exp_sel() && cyc_read && (m_pin == 1 || m_sr == 1);
  endfunction

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      int lo;
      int hi;
      lo = 2048 + (m_sr << 10) + (m_re << 9) - 2048 + 511;
      check(int'(reg_rdata[10:0]) == lo, "R2 rdata low", int'(reg_rdata[10:0]), lo);
      if (base_known) begin
        hi = m_base;
        check(int'(reg_rdata[15:11]) == hi, "R2 rdata base", int'(reg_rdata[15:11]), hi);
      end
      check(ram_sel == exp_sel(), "R4 ram_sel", int'(ram_sel), int'(exp_sel()));
      check(ram_ready == exp_sel(), "R6 ram_ready", int'(ram_ready), int'(exp_sel()));
      check(ext_oe == exp_oe(), "R7 ext_oe", int'(ext_oe), int'(exp_oe()));
      check(ext_data == (exp_oe() ? ram_rdata : 16'h0), "R9 ext_data",
            int'(ext_data), exp_oe() ? int'(ram_rdata) : 0);
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [4:0] base, input logic sr, input logic re, input logic [8:0] rsv);
    step();
    cyc_valid = 1'b0;
    reg_we    = 1'b1;
    reg_wdata = {base, sr, re, rsv};
    step();
    reg_we    = 1'b0;
  endtask

  task automatic cyc(input logic [19:0] a, input logic rd, input logic [15:0] d);
    step();
    cyc_valid = 1'b1;
    cyc_addr  = a;
    cyc_read  = rd;
    ram_rdata = d;
  endtask

  task automatic do_reset(input logic pin);
    step();
    rst = 1'b1;
    sr_pin = pin;
    cyc_valid = 1'b0;
    reg_we = 1'b0;
    repeat (3) step();
    rst = 1'b0;
  endtask

  task automatic rand_phase(input int n);
    for (int i = 0; i < n; i++) begin
      step();
      reg_we    = ($urandom % 8) == 0;
      reg_wdata = 16'($urandom);
      cyc_valid = ($urandom % 4) != 0;
      cyc_addr  = 20'($urandom);
      if (($urandom % 2) == 0 && base_known) cyc_addr[19:15] = 5'(m_base);
      cyc_read  = 1'($urandom);
      ram_rdata = 16'($urandom);
      if (($urandom % 16) == 0) sr_pin = ~sr_pin;
    end
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    @(negedge clk); #1;
    // R1: reset value of show and enable, reserved ones
    check(reg_rdata[10:0] == 11'h1FF, "R1 reset rdata", int'(reg_rdata[10:0]), 'h1FF);

    // R5: base set but enable clear keeps the window shut
    wr(5'd3, 1'b0, 1'b0, 9'h0);
    cyc(20'h1_8004, 1'b1, 16'hA5A5);
    @(negedge clk); #1;
    check(ram_sel == 1'b0, "R5 sel without enable", int'(ram_sel), 0);

    // R3: write then next-cycle readback
    wr(5'd3, 1'b0, 1'b1, 9'h0);
    @(negedge clk); #1;
    check(reg_rdata == 16'h1BFF, "R3 readback", int'(reg_rdata), 'h1BFF);
    cyc(20'h1_FFFE, 1'b1, 16'h1234);
    @(negedge clk); #1;
    check(ram_sel && ram_ready && !ext_oe, "R4 hit no show", int'({ram_sel, ram_ready, ext_oe}), 'b110);
    cyc(20'h2_0000, 1'b1, 16'h1234);
    @(negedge clk); #1;
    check(!ram_sel, "R4 miss above", int'(ram_sel), 0);

    // R7, R9: show-read via register bit, byte-lane data on both lanes
    wr(5'd3, 1'b1, 1'b1, 9'h0);
    cyc(20'h1_8001, 1'b1, 16'hBEEF);
    @(negedge clk); #1;
    check(ext_oe && ext_data == 16'hBEEF, "R7 R9 shown read", int'(ext_data), 'hBEEF);
    // R10: write hit and read miss do not drive
    cyc(20'h1_8002, 1'b0, 16'hBEEF);
    @(negedge clk); #1;
    check(!ext_oe && ext_data == 16'h0, "R10 write hit", int'(ext_oe), 0);
    cyc(20'h0_8002, 1'b1, 16'hBEEF);
    @(negedge clk); #1;
    check(!ext_oe, "R10 read miss", int'(ext_oe), 0);

    rand_phase(400);

    // R8: pin sampled in reset forces show-read, later pin changes ignored
    do_reset(1'b1);
    wr(5'd9, 1'b0, 1'b1, 9'h0);
    sr_pin = 1'b0;
    cyc(20'h4_9000, 1'b1, 16'h00C3);
    @(negedge clk); #1;
    check(ext_oe && ext_data == 16'h00C3, "R8 forced show", int'(ext_data), 'hC3);
    rand_phase(400);

    do_reset(1'b0);
    wr(5'd9, 1'b0, 1'b1, 9'h0);
    sr_pin = 1'b1;
    cyc(20'h4_9000, 1'b1, 16'h00C3);
    @(negedge clk); #1;
    check(!ext_oe, "R8 pin ignored outside reset", int'(ext_oe), 0);
    rand_phase(400);

    step();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule